// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block sends one control bit per output stream and channel of a time slot switch on a single serial pin. Each frame has 32 channels of 8 bit periods, at one bit per clock (2.048 Mb/s). The block steps through that frame and, once per channel, fetches an 8-bit word from the per-channel control store. Bit s of the word belongs to output stream s. The block then shifts the word out, lowest stream first.

The output runs one channel ahead of the serial data streams. While channel k is on the data streams, the control pin carries the bits of channel k+1, so external circuitry has a full channel period to act on a bit before its channel arrives. The frame pulse aligns the block. Between pulses the block runs freely and wraps every 256 bit periods.

The control store sits outside the block. Its read port is combinational: the block presents a channel number, and the store returns that channel's word in the same cycle. The block captures the word on the next clock edge.

Top module: `ctlbit_serializer`

## Requirements
- R1: While reset is active, and from reset until the first clock edge that samples `frm_i` high, `ctl_o` is low and `rd_en` stays low.
- R2: When `frm_i` is sampled high at a clock edge, the next cycle is the first bit period (bit 7) of data channel 0. In the cycle that samples the pulse, `rd_en` is high and `rd_chan` is 1. During the cycle after the pulse, `ctl_o` carries stream 0 of channel 1.
- R3: Let j run from 0 to 7 through the 8 cycles of data channel k, so that cycle j is bit 7−j. In cycle j, `ctl_o` equals bit j of the control word of channel (k+1) mod 32, where bit j is stream j. A stored 1 drives the pin high and a stored 0 drives it low.
- R4: The window of data channel 31 carries the word of channel 0. Stream 0 of channel 0 therefore goes out during bit 7 of channel 31 of the frame before.
- R5: Once the block is aligned, `rd_en` is high in the last cycle of every channel window and in every pulse cycle, and in no other cycle. While `rd_en` is high, `rd_chan` is one more (mod 32) than the data channel that begins on the next cycle.
- R6: With no further frame pulses, the output pattern repeats every 256 cycles, because the position wraps from channel 31 bit 0 to channel 0 bit 7.
- R7: A frame pulse at any phase, including the middle of a channel, realigns the block. The next cycle becomes channel 0 bit 7, whatever the earlier position was.
- R8: The block captures the control word at the fetch edge. A change to the stored word after that edge has no effect on the current window. The new value appears at the next fetch of that channel, one frame later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one cycle per serial bit period |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_i | input | 1 | Frame pulse; high in the cycle before channel 0 bit 7 |
| rd_en | output | 1 | Fetch strobe to the control store, one cycle per channel |
| rd_chan | output | 5 | Channel number whose control word is read |
| rd_data | input | 8 | Control word of `rd_chan`; bit s is stream s |
| ctl_o | output | 1 | Serial control bit output |

## Verification
A wrong frame position or an off-by-one in the channel lead makes `rd_chan` disagree with the expected channel on the very next fetch strobe. The bits that go out in the following window then come from the wrong channel, so the error shows at the ports within 8 cycles. A wrong stream order inside the shift register affects only the bits inside one window, and it shows up once the words in the store differ from one stream to the next; for that reason the bench uses random words together with single-bit and all-ones patterns. A defect in capture or realignment shows up only when the bench modifies the store in the middle of a window or sends a pulse out of phase, and both stimuli are driven on purpose.

// File: rtl/ctlbit_pkg.sv
// Package: shared defaults and helpers for the control bit serializer.
// Assumes: all widths used by the modules are derived from these values.
package ctlbit_pkg;

    localparam int unsigned DEF_STREAMS  = 8;   // bit periods per channel = streams
    localparam int unsigned DEF_CHANNELS = 32;  // channels per frame
    localparam int unsigned DEF_LEAD     = 1;   // channels the control bit runs ahead

    // Modular add of a variable index and a constant offset, no divider.
    function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned m);
        int unsigned s;
        s = a + (b % m);
        if (s >= m) s = s - m;
        return s;
    endfunction

endpackage

// File: rtl/ctlbit_frame_pos.sv
// Module: frame position tracker.
// Keeps the current bit index within a channel and the channel index within
// the frame, and publishes the position of the next cycle combinationally.
// Assumes: frm_i high at an edge means the next cycle is channel 0, first bit.
module ctlbit_frame_pos #(
    parameter int unsigned STREAMS  = ctlbit_pkg::DEF_STREAMS,
    parameter int unsigned CHANNELS = ctlbit_pkg::DEF_CHANNELS,
    localparam int unsigned BIT_W   = (STREAMS  > 1) ? $clog2(STREAMS)  : 1,
    localparam int unsigned CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_i,
    output logic             running,
    output logic [BIT_W-1:0] nxt_bit,
    output logic [CH_W-1:0]  nxt_chan
);

    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(STREAMS - 1);
    localparam logic [CH_W-1:0]  LAST_CHAN = CH_W'(CHANNELS - 1);

    logic             synced_q;
    logic [BIT_W-1:0] bit_q;
    logic [CH_W-1:0]  chan_q;

    // Next position: restart on a pulse, else advance and wrap.
    always_comb begin
        running  = synced_q | frm_i;
        nxt_bit  = '0;
        nxt_chan = '0;
        if (!frm_i) begin
            if (bit_q == LAST_BIT) begin
                nxt_bit  = '0;
                nxt_chan = (chan_q == LAST_CHAN) ? '0 : chan_q + 1'b1;
            end else begin
                nxt_bit  = bit_q + 1'b1;
                nxt_chan = chan_q;
            end
        end
    end

    // Position registers; frozen until the first pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q <= 1'b0;
            bit_q    <= '0;
            chan_q   <= '0;
        end else if (running) begin
            synced_q <= 1'b1;
            bit_q    <= nxt_bit;
            chan_q   <= nxt_chan;
        end
    end

endmodule

// File: rtl/ctlbit_fetch.sv
// Module: fetch strobe and address generator.
// Raises the strobe on the cycle before each channel window and addresses
// the channel that runs LEAD channels ahead of the upcoming window.
// Assumes: the control store answers combinationally in the same cycle.
module ctlbit_fetch #(
    parameter int unsigned STREAMS  = ctlbit_pkg::DEF_STREAMS,
    parameter int unsigned CHANNELS = ctlbit_pkg::DEF_CHANNELS,
    parameter int unsigned LEAD     = ctlbit_pkg::DEF_LEAD,
    localparam int unsigned BIT_W   = (STREAMS  > 1) ? $clog2(STREAMS)  : 1,
    localparam int unsigned CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic             running,
    input  logic [BIT_W-1:0] nxt_bit,
    input  logic [CH_W-1:0]  nxt_chan,
    output logic             rd_en,
    output logic [CH_W-1:0]  rd_chan
);

    localparam int unsigned LEAD_M = LEAD % CHANNELS;

    // Strobe when the next cycle opens a channel window.
    always_comb rd_en = running && (nxt_bit == '0);

    // Address: upcoming channel plus the lead, modulo the frame length.
    generate
        if (LEAD_M == 0) begin : g_no_lead
            always_comb rd_chan = nxt_chan;
        end else begin : g_lead
            logic [CH_W:0] sum;
            always_comb begin
                sum = {1'b0, nxt_chan} + (CH_W+1)'(LEAD_M);
                if (sum >= (CH_W+1)'(CHANNELS)) sum = sum - (CH_W+1)'(CHANNELS);
                rd_chan = sum[CH_W-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/ctlbit_shifter.sv
// Module: load-and-shift serializer.
// Captures a word on load and emits bit 0 first, one bit per cycle, on a
// registered output. Holds the output low until the frame is aligned.
// Assumes: STREAMS >= 2.
module ctlbit_shifter #(
    parameter int unsigned STREAMS = ctlbit_pkg::DEF_STREAMS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               running,
    input  logic               load,
    input  logic [STREAMS-1:0] din,
    output logic               ser_o
);

    logic [STREAMS-1:0] sh_q;
    logic               out_q;

    // Load a fresh word or shift the held word toward the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            out_q <= 1'b0;
        end else if (load) begin
            out_q <= din[0];
            sh_q  <= {1'b0, din[STREAMS-1:1]};
        end else if (running) begin
            out_q <= sh_q[0];
            sh_q  <= {1'b0, sh_q[STREAMS-1:1]};
        end
    end

    // Drive the pin from the output register.
    always_comb ser_o = out_q;

endmodule

// File: rtl/ctlbit_serializer.sv
// Module: per-channel control bit serializer (top).
// Sends one control bit per stream and channel, one channel ahead of the
// data streams, fetching one word per channel from an external store.
// Assumes: one clock per bit period; combinational read of the store.
module ctlbit_serializer #(
    parameter int unsigned STREAMS  = ctlbit_pkg::DEF_STREAMS,
    parameter int unsigned CHANNELS = ctlbit_pkg::DEF_CHANNELS,
    parameter int unsigned LEAD     = ctlbit_pkg::DEF_LEAD,
    localparam int unsigned BIT_W   = (STREAMS  > 1) ? $clog2(STREAMS)  : 1,
    localparam int unsigned CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_i,
    output logic               rd_en,
    output logic [CH_W-1:0]    rd_chan,
    input  logic [STREAMS-1:0] rd_data,
    output logic               ctl_o
);

    logic             running;
    logic [BIT_W-1:0] nxt_bit;
    logic [CH_W-1:0]  nxt_chan;

    ctlbit_frame_pos #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_i    (frm_i),
        .running  (running),
        .nxt_bit  (nxt_bit),
        .nxt_chan (nxt_chan)
    );

    ctlbit_fetch #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .LEAD(LEAD)) u_fetch (
        .running  (running),
        .nxt_bit  (nxt_bit),
        .nxt_chan (nxt_chan),
        .rd_en    (rd_en),
        .rd_chan  (rd_chan)
    );

    ctlbit_shifter #(.STREAMS(STREAMS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .load    (rd_en),
        .din     (rd_data),
        .ser_o   (ctl_o)
    );

endmodule

// File: rtl/ctlbit_checker.sv
// Module: port-level property checker for the control bit serializer.
// Tracks alignment and fetch spacing on its own and checks the ports.
module ctlbit_checker #(
    parameter int unsigned STREAMS  = ctlbit_pkg::DEF_STREAMS,
    parameter int unsigned CHANNELS = ctlbit_pkg::DEF_CHANNELS,
    parameter int unsigned LEAD     = ctlbit_pkg::DEF_LEAD,
    localparam int unsigned CH_W    = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
    localparam int unsigned GW      = $clog2(STREAMS + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frm_i,
    input logic            rd_en,
    input logic [CH_W-1:0] rd_chan,
    input logic            din0,
    input logic            ctl_o
);

    logic          seen_q;
    logic [GW-1:0] gap_q;

    // Remember whether any frame pulse has been sampled since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     seen_q <= 1'b0;
        else if (frm_i) seen_q <= 1'b1;
    end

    // Count cycles since the last fetch strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                    gap_q <= '0;
        else if (rd_en)                gap_q <= '0;
        else if (gap_q < GW'(STREAMS)) gap_q <= gap_q + 1'b1;
    end

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !ctl_o);

    assert_idle_nofetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && !frm_i) |-> !rd_en);

    assert_pulse_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_i |-> (rd_en && rd_chan == CH_W'(LEAD % CHANNELS)));

    assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (ctl_o == $past(din0)));

    assert_fetch_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !frm_i && gap_q == GW'(STREAMS - 1)) |-> rd_en);

    assert_fetch_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !frm_i) |-> (gap_q == GW'(STREAMS - 1)));

endmodule

bind ctlbit_serializer ctlbit_checker #(
    .STREAMS(STREAMS), .CHANNELS(CHANNELS), .LEAD(LEAD)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frm_i   (frm_i),
    .rd_en   (rd_en),
    .rd_chan (rd_chan),
    .din0    (rd_data[0]),
    .ctl_o   (ctl_o)
);

// File: tb/tb_ctlbit_serializer.sv
module tb_ctlbit_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int STREAMS    = 8;
    localparam int CHANNELS   = 32;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_i = 1'b0;
    logic       rd_en;
    logic [4:0] rd_chan;
    logic [7:0] rd_data;
    logic       ctl_o;

    logic [7:0] mem [CHANNELS];
    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    // Bench reference state, built from the requirements.
    bit         m_sync = 0;
    int         m_bit  = 0;
    int         m_chan = 0;
    logic [7:0] latched = '0;
    bit         after_pulse = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rd_data = mem[rd_chan];

    ctlbit_serializer dut (
        .clk(clk), .rst_n(rst_n), .frm_i(frm_i),
        .rd_en(rd_en), .rd_chan(rd_chan), .rd_data(rd_data), .ctl_o(ctl_o)
    );

    task automatic check(bit ok, string req, int act, int exp, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int ahead(int c);
        return (c + 1) % CHANNELS;
    endfunction

    // One bit period: drive pulse, check fetch, advance, check the pin.
    task automatic step(bit pulse, string req_ovr);
        int nb, nc, expv;
        bit run, exp_en;
        logic [7:0] nw;
        string req;
        nw = '0;
        frm_i = pulse;
        #1;
        run = m_sync || pulse;
        if (pulse) begin nb = 0; nc = 0; end
        else if (m_bit == STREAMS-1) begin nb = 0; nc = (m_chan + 1) % CHANNELS; end
        else begin nb = m_bit + 1; nc = m_chan; end
        exp_en = run && (nb == 0);
        check(rd_en == exp_en, run ? (pulse ? "R2" : "R5") : "R1", rd_en, exp_en, "fetch strobe");
        if (exp_en) begin
            check(rd_chan == ahead(nc), pulse ? "R2" : "R5", rd_chan, ahead(nc), "fetch channel");
            nw = mem[ahead(nc)];
        end
        @(posedge clk);
        if (run) begin
            m_sync = 1; m_bit = nb; m_chan = nc;
            if (exp_en) latched = nw;
        end
        after_pulse = pulse;
        @(negedge clk);
        frm_i = 1'b0;
        expv = m_sync ? int'(latched[m_bit]) : 0;
        if (req_ovr != "")                req = req_ovr;
        else if (!m_sync)                 req = "R1";
        else if (after_pulse)             req = "R2";
        else if (m_chan == CHANNELS - 1)  req = "R4";
        else                              req = "R3";
        check(ctl_o == expv, req, ctl_o, expv, "serial bit");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired, all requirements unchecked");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int c;
        logic [7:0] old;
        void'($urandom(32'd4711));
        for (int i = 0; i < CHANNELS; i++) mem[i] = 8'($urandom);
        // Directed patterns: single bits, all ones, all zeros, the wrap channel.
        mem[0] = 8'h01; mem[1] = 8'hA5; mem[2] = 8'hFF; mem[3] = 8'h00; mem[31] = 8'h80;

        // R1: reset state and idle before the first pulse.
        repeat (3) @(negedge clk);
        check(ctl_o == 1'b0, "R1", ctl_o, 0, "output in reset");
        check(rd_en == 1'b0, "R1", rd_en, 0, "strobe in reset");
        rst_n = 1'b1;
        repeat (20) step(0, "");

        // R2, R3, R4: first aligned frame.
        step(1, "");
        repeat (255) step(0, "");

        // R6: free running for two frames with new words.
        repeat (2) begin
            for (int i = 0; i < CHANNELS; i++) mem[i] = 8'($urandom);
            repeat (256) step(0, "R6");
        end

        // R7: an in-phase pulse, then one in the middle of a channel.
        step(1, "R7");
        repeat (100) step(0, "");
        step(1, "R7");
        repeat (300) step(0, "");

        // Random phases and store writes.
        repeat (8) begin
            n = $urandom_range(3, 400);
            mem[$urandom_range(0, CHANNELS-1)] = 8'($urandom);
            repeat (n) step(0, "");
            step(1'($urandom_range(0, 1)), "");
        end

        // R8: rewrite the word of the channel currently going out.
        while (m_bit != 0) step(0, "");
        c = ahead(m_chan);
        old = mem[c];
        mem[c] = ~old;
        repeat (7) step(0, "R8");
        repeat (256) step(0, "R8");
        check(latched == ~old || m_bit != 7 || ahead(m_chan) != c, "R8", latched, ~old, "new word fetched");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule